// File: doc/BRIEF.md
# DMA Controller Host Register File

This block is the host-facing register file of a four-channel DMA controller of the classic kind. A processor reaches it through a byte-wide I/O port bus: a 4-bit port offset, write data, a write strobe and a read strobe. Each channel keeps a 16-bit base address, a 16-bit current address, a 16-bit base count and a 16-bit current count. These are loaded and read one byte at a time through one port per register. A single byte-pointer flip-flop, shared by all channels, selects which byte each access uses.

The same port space holds the per-channel mode registers, the four request mask bits, a command register whose disable bit turns the whole controller off, and a status register. The status register carries terminal-count flags and the live request lines.

On the engine side, the block drives each channel's current address, current count, mode and mask to a transfer engine. It takes back three per-channel signals from that engine: step pulses, terminal-count pulses and request levels. A step moves the current registers by one. A terminal-count pulse sets a status flag and, on channels with auto-initialise set, reloads the current registers from the base registers.

Top module: `dmac_regfile`

## Requirements
- R1: After reset all address and count registers and mode fields are zero, all four mask bits are set, the disable output is low, the byte pointer selects the low byte, and io_rdata is zero whenever no read is in progress.
- R2: A write to offset 2n (n = 0..3) loads channel n's address register, and a write to offset 2n+1 loads its count register. With the pointer low the data goes to bits [7:0], with the pointer high it goes to bits [15:8]. Each write loads both the base copy and the current copy.
- R3: Every read or write at offsets 0..7 toggles the one shared byte pointer, whatever the channel. A read there returns the selected byte (low when the pointer is low, high when it is high) of the current address (even offset) or the current count (odd offset).
- R4: Any write to offset 12 sets the byte pointer to low, whatever the data.
- R5: A write to offset 12+1 = 13 sets the pointer low, clears all terminal-count flags and sets all four mask bits. Addresses, counts, modes and the command register keep their values.
- R6: A write to offset 10 sets the mask bit of channel data[1:0] to data[2] and leaves the other three mask bits as they were.
- R7: A write to offset 14 clears all four mask bits. A write to offset 15 loads mask bit n from data bit n.
- R8: A write to offset 11 stores data[7:2] as the mode of channel data[1:0]. ch_mode[6n+5:6n] carries data[7:2] of that write, so the bits are: [1:0] transfer type, [2] auto-initialise, [3] address decrement, [5:4] transfer mode.
- R9: A write to offset 8 stores data[2], and ctrl_disable follows that stored bit.
- R10: A read at offset 8 returns {eng_req[3:0], tc_flags[3:0]} and clears the terminal-count flags. A terminal-count pulse in the same cycle as that read still sets its flag.
- R11: An eng_step pulse on channel n decrements its current count by one. It increments the current address by one, or decrements it by one when the channel's decrement bit is set. Both registers wrap modulo 2^16.
- R12: An eng_tc pulse on channel n sets flag n. If channel n has auto-initialise set, its current address and current count are reloaded from the base copies; otherwise they are unchanged. A reload takes priority over a step in the same cycle, and a host write to the same register takes priority over both.
- R13: A write to offset 9 has no effect, a read at offset 9 returns zero, and a read and a write in the same cycle act as the write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data |
| io_wr | input | 1 | Write strobe, one access per cycle |
| io_rd | input | 1 | Read strobe, one access per cycle |
| io_rdata | output | 8 | Read data, valid while io_rd is high |
| eng_step | input | 4 | Per-channel one-cycle step pulse |
| eng_tc | input | 4 | Per-channel terminal-count pulse |
| eng_req | input | 4 | Per-channel live request level |
| cur_addr | output | 64 | Current address, channel n at [16n+15:16n] |
| cur_cnt | output | 64 | Current count, channel n at [16n+15:16n] |
| ch_mode | output | 24 | Mode of channel n at [6n+5:6n] |
| ch_mask | output | 4 | Mask bit per channel |
| ctrl_disable | output | 1 | Controller disable from the command register |

## Verification
The block has a fixed geometry of four channels and 16-bit registers, and the bench builds it as it is. With 16 bits, one step after loading 0xFFFF or 0x0000 reaches the address and count wrap points. With four channels, a single sequence can show the shared byte pointer carrying from one channel's port into another's. The reference model is compared with every output on every clock, so priority collisions such as a terminal-count pulse during a status read are checked as they occur.

// File: rtl/dmac_regfile.sv
module dmac_regfile (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  io_addr,
  input  logic [7:0]  io_wdata,
  input  logic        io_wr,
  input  logic        io_rd,
  output logic [7:0]  io_rdata,
  input  logic [3:0]  eng_step,
  input  logic [3:0]  eng_tc,
  input  logic [3:0]  eng_req,
  output logic [63:0] cur_addr,
  output logic [63:0] cur_cnt,
  output logic [23:0] ch_mode,
  output logic [3:0]  ch_mask,
  output logic        ctrl_disable
);
  localparam int NCH = 4;
  localparam int RW  = 16;
  localparam int MW  = 6;

  logic [MW-1:0] mode_q [NCH];
  logic [NCH-1:0] mask_q, tc_q;
  logic ptr_q, dis_q;

  logic reg_sel, sel_cnt, rd_act, wr_reg, rd_reg, rd_stat;
  logic [1:0] sel_ch;
  logic [RW-1:0] rd_word;

  assign reg_sel = ~io_addr[3];
  assign sel_ch  = io_addr[2:1];
  assign sel_cnt = io_addr[0];
  assign rd_act  = io_rd & ~io_wr;
  assign wr_reg  = io_wr & reg_sel;
  assign rd_reg  = rd_act & reg_sel;
  assign rd_stat = rd_act & (io_addr == 4'd8);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= 1'b0;
      dis_q  <= 1'b0;
      mask_q <= '1;
      tc_q   <= '0;
      for (int i = 0; i < NCH; i++) mode_q[i] <= '0;
    end else begin
      if (io_wr && (io_addr == 4'd12 || io_addr == 4'd13)) ptr_q <= 1'b0;
      else if (wr_reg || rd_reg)                           ptr_q <= ~ptr_q;

      if (io_wr && io_addr == 4'd8) dis_q <= io_wdata[2];

      if (io_wr && io_addr == 4'd13)      mask_q <= '1;
      else if (io_wr && io_addr == 4'd14) mask_q <= '0;
      else if (io_wr && io_addr == 4'd15) mask_q <= io_wdata[NCH-1:0];
      else if (io_wr && io_addr == 4'd10) mask_q[io_wdata[1:0]] <= io_wdata[2];

      if (io_wr && io_addr == 4'd11) mode_q[io_wdata[1:0]] <= io_wdata[7:2];

      if (io_wr && io_addr == 4'd13) tc_q <= '0;
      else                           tc_q <= (rd_stat ? '0 : tc_q) | eng_tc;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [RW-1:0] ba_q, ca_q, bc_q, cc_q;
    logic hit_a, hit_c, reload;

    assign hit_a  = wr_reg && (sel_ch == 2'(g)) && !sel_cnt;
    assign hit_c  = wr_reg && (sel_ch == 2'(g)) &&  sel_cnt;
    assign reload = eng_tc[g] && mode_q[g][2];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ba_q <= '0;
        ca_q <= '0;
        bc_q <= '0;
        cc_q <= '0;
      end else begin
        if (hit_a) begin
          if (ptr_q) begin
            ba_q[15:8] <= io_wdata;
            ca_q[15:8] <= io_wdata;
          end else begin
            ba_q[7:0] <= io_wdata;
            ca_q[7:0] <= io_wdata;
          end
        end else if (reload) begin
          ca_q <= ba_q;
        end else if (eng_step[g]) begin
          ca_q <= mode_q[g][3] ? ca_q - 1'b1 : ca_q + 1'b1;
        end

        if (hit_c) begin
          if (ptr_q) begin
            bc_q[15:8] <= io_wdata;
            cc_q[15:8] <= io_wdata;
          end else begin
            bc_q[7:0] <= io_wdata;
            cc_q[7:0] <= io_wdata;
          end
        end else if (reload) begin
          cc_q <= bc_q;
        end else if (eng_step[g]) begin
          cc_q <= cc_q - 1'b1;
        end
      end
    end

    assign cur_addr[g*RW +: RW] = ca_q;
    assign cur_cnt[g*RW +: RW]  = cc_q;
    assign ch_mode[g*MW +: MW]  = mode_q[g];
  end

  assign rd_word = sel_cnt ? cur_cnt[{sel_ch, 4'b0000} +: RW]
                           : cur_addr[{sel_ch, 4'b0000} +: RW];

  always_comb begin
    io_rdata = '0;
    if (rd_reg)       io_rdata = ptr_q ? rd_word[15:8] : rd_word[7:0];
    else if (rd_stat) io_rdata = {eng_req, tc_q};
  end

  assign ch_mask      = mask_q;
  assign ctrl_disable = dis_q;
endmodule

// File: rtl/dmac_regfile_chk.sv
module dmac_regfile_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] io_addr,
  input logic [7:0] io_wdata,
  input logic       io_wr,
  input logic       io_rd,
  input logic [7:0] io_rdata,
  input logic [3:0] eng_tc,
  input logic [3:0] ch_mask,
  input logic       ctrl_disable,
  input logic       ptr_q,
  input logic [3:0] tc_q
);
  p_idle_rdata_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |-> io_rdata == 8'h00);

  p_ptr_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((io_wr || io_rd) && !io_addr[3]) |=> ptr_q != $past(ptr_q));

  p_ff_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'd12) |=> !ptr_q);

  p_master_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'd13) |=> (ch_mask == 4'hF && tc_q == 4'h0 && !ptr_q));

  p_single_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'd10) |=> ch_mask[$past(io_wdata[1:0])] == $past(io_wdata[2]));

  p_mask_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'd14) |=> ch_mask == 4'h0);

  p_command_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 4'd8) |=> ctrl_disable == $past(io_wdata[2]));

  p_status_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_wr && io_addr == 4'd8 && eng_tc == 4'h0) |=> tc_q == 4'h0);

  p_tc_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ((|eng_tc) && !(io_wr && io_addr == 4'd13)) |=> (tc_q & $past(eng_tc)) == $past(eng_tc));
endmodule

bind dmac_regfile dmac_regfile_chk chk_i (.*);

// File: tb/dmac_regfile_tb_top.sv
module dmac_regfile_tb_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic [3:0] io_addr = '0;
  logic [7:0] io_wdata = '0;
  logic io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0] io_rdata;
  logic [3:0] eng_step = '0, eng_tc = '0, eng_req = '0;
  logic [63:0] cur_addr, cur_cnt;
  logic [23:0] ch_mode;
  logic [3:0] ch_mask;
  logic ctrl_disable;

  dmac_regfile dut_i (.*);

  int n_tests = 0, n_fail = 0;
  string tag = "R1";

  int ba[4], ca[4], bc[4], cc[4], md[4];
  int msk = 15, dis = 0, tcf = 0, ptr = 0;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_rd();
    int a = int'(io_addr);
    int w;
    if (!io_rd || io_wr) return 0;
    if (a < 8) begin
      w = (a % 2 == 1) ? cc[a / 2] : ca[a / 2];
      return ptr ? (w >> 8) & 255 : w & 255;
    end
    if (a == 8) return (int'(eng_req) << 4) | tcf;
    return 0;
  endfunction

  task automatic model_step();
    int a = int'(io_addr);
    int d = int'(io_wdata);
    bit wr = io_wr;
    bit rd = io_rd && !io_wr;
    for (int n = 0; n < 4; n++) begin
      bit hit_a = wr && a < 8 && a / 2 == n && a % 2 == 0;
      bit hit_c = wr && a < 8 && a / 2 == n && a % 2 == 1;
      bit rl = eng_tc[n] && md[n][2];
      if (hit_a) begin
        ba[n] = ptr ? (ba[n] & 'hff) | (d << 8) : (ba[n] & 'hff00) | d;
        ca[n] = ptr ? (ca[n] & 'hff) | (d << 8) : (ca[n] & 'hff00) | d;
      end else if (rl) ca[n] = ba[n];
      else if (eng_step[n]) ca[n] = (md[n][3] ? ca[n] + 65535 : ca[n] + 1) & 'hffff;
      if (hit_c) begin
        bc[n] = ptr ? (bc[n] & 'hff) | (d << 8) : (bc[n] & 'hff00) | d;
        cc[n] = ptr ? (cc[n] & 'hff) | (d << 8) : (cc[n] & 'hff00) | d;
      end else if (rl) cc[n] = bc[n];
      else if (eng_step[n]) cc[n] = (cc[n] + 65535) & 'hffff;
    end
    if (wr && a == 13) tcf = 0;
    else tcf = ((rd && a == 8) ? 0 : tcf) | int'(eng_tc);
    if (wr && (a == 12 || a == 13)) ptr = 0;
    else if ((wr || rd) && a < 8) ptr = ptr ^ 1;
    if (wr && a == 8) dis = (d >> 2) & 1;
    if (wr && a == 13) msk = 15;
    else if (wr && a == 14) msk = 0;
    else if (wr && a == 15) msk = d & 15;
    else if (wr && a == 10) msk = ((d >> 2) & 1) ? msk | (1 << (d & 3)) : msk & ~(1 << (d & 3));
    if (wr && a == 11) md[d & 3] = d >> 2;
  endtask

  task automatic check_all();
    logic [63:0] ea, ec;
    logic [23:0] em;
    for (int n = 0; n < 4; n++) begin
      ea[n*16 +: 16] = 16'(ca[n]);
      ec[n*16 +: 16] = 16'(cc[n]);
      em[n*6 +: 6]   = 6'(md[n]);
    end
    chk("cur_addr", cur_addr, ea);
    chk("cur_cnt", cur_cnt, ec);
    chk("ch_mode", 64'(ch_mode), 64'(em));
    chk("ch_mask", 64'(ch_mask), 64'(msk));
    chk("ctrl_disable", 64'(ctrl_disable), 64'(dis));
  endtask

  task automatic tick();
    #1;
    chk("io_rdata", 64'(io_rdata), 64'(exp_rd()));
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic wr(int a, int d);
    io_addr = 4'(a); io_wdata = 8'(d); io_wr = 1'b1;
    tick();
    io_wr = 1'b0;
  endtask

  task automatic rd(int a);
    io_addr = 4'(a); io_rd = 1'b1;
    tick();
    io_rd = 1'b0;
  endtask

  task automatic eng(logic [3:0] st, logic [3:0] tc);
    eng_step = st; eng_tc = tc;
    tick();
    eng_step = '0; eng_tc = '0;
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int n = 0; n < 4; n++) begin ba[n] = 0; ca[n] = 0; bc[n] = 0; cc[n] = 0; md[n] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tag = "R1";
    check_all();
    chk("mask after reset", 64'(ch_mask), 64'hF);
    tick();

    tag = "R2";
    wr(0, 'h34); wr(0, 'h12);
    wr(3, 'hff); wr(3, 'h00);
    wr(6, 'hcd); wr(6, 'hab);
    chk("ch0 addr", 64'(cur_addr[15:0]), 64'h1234);
    chk("ch1 count", 64'(cur_cnt[31:16]), 64'h00ff);
    chk("ch3 addr", 64'(cur_addr[63:48]), 64'habcd);

    tag = "R3";
    rd(0); rd(0); rd(3); rd(3);
    wr(4, 'h11); wr(5, 'h22);
    chk("shared pointer ch2 count high", 64'(cur_cnt[47:40]), 64'h22);

    tag = "R4";
    wr(4, 'h77); wr(12, 'ha5); wr(4, 'h88); wr(4, 'h99);
    chk("ch2 addr", 64'(cur_addr[47:32]), 64'h9988);

    tag = "R5";
    eng(4'b0000, 4'b0011);
    wr(15, 0);
    wr(0, 'h01);
    wr(13, 'h00);
    chk("mask set", 64'(ch_mask), 64'hF);
    rd(8);
    rd(0);

    tag = "R6";
    wr(10, 'h01); wr(10, 'h03); wr(10, 'h05);
    chk("single mask", 64'(ch_mask), 64'h7);

    tag = "R7";
    wr(14, 'hff);
    chk("mask clear", 64'(ch_mask), 64'h0);
    wr(15, 'hfa);
    chk("all mask", 64'(ch_mask), 64'ha);

    tag = "R8";
    wr(11, 'hb6);
    chk("ch2 mode", 64'(ch_mode[17:12]), 64'h2d);
    wr(11, 'h55);
    chk("ch1 mode", 64'(ch_mode[11:6]), 64'h15);

    tag = "R9";
    wr(8, 'h04);
    chk("disable set", 64'(ctrl_disable), 64'h1);
    wr(8, 'hfb);
    chk("disable clear", 64'(ctrl_disable), 64'h0);

    tag = "R10";
    eng_req = 4'b1010;
    eng(4'b0000, 4'b0100);
    io_addr = 4'd8; io_rd = 1'b1; #1;
    chk("status read", 64'(io_rdata), 64'ha4);
    tick(); io_rd = 1'b0;
    rd(8);
    eng_tc = 4'b0001; io_addr = 4'd8; io_rd = 1'b1;
    tick();
    io_rd = 1'b0; eng_tc = '0;
    io_addr = 4'd8; io_rd = 1'b1; #1;
    chk("tc kept over clear", 64'(io_rdata), 64'ha1);
    tick(); io_rd = 1'b0;

    tag = "R11";
    wr(12, 0);
    wr(6, 'hff); wr(6, 'hff); wr(7, 'h01); wr(7, 'h00);
    wr(11, 'h03);
    eng(4'b1000, 4'b0000);
    chk("addr wrap up", 64'(cur_addr[63:48]), 64'h0000);
    chk("count step", 64'(cur_cnt[63:48]), 64'h0000);
    eng(4'b1000, 4'b0000);
    chk("count wrap", 64'(cur_cnt[63:48]), 64'hffff);
    wr(11, 'h23);
    eng(4'b1000, 4'b0000);
    chk("addr decrement", 64'(cur_addr[63:48]), 64'h0000);
    eng(4'b1000, 4'b0000);
    chk("addr wrap down", 64'(cur_addr[63:48]), 64'hffff);

    tag = "R12";
    wr(12, 0);
    wr(0, 'h00); wr(0, 'h40); wr(1, 'h10); wr(1, 'h00);
    wr(11, 'h10);
    wr(11, 'h45);
    repeat (3) eng(4'b0001, 4'b0000);
    chk("ch0 stepped", 64'(cur_addr[15:0]), 64'h4003);
    chk("ch0 count stepped", 64'(cur_cnt[15:0]), 64'h000d);
    eng(4'b0001, 4'b0001);
    chk("ch0 reload", 64'(cur_addr[15:0]), 64'h4000);
    chk("ch0 count reload", 64'(cur_cnt[15:0]), 64'h0010);
    eng(4'b0010, 4'b0000);
    eng(4'b0000, 4'b0010);
    chk("ch1 no reload", 64'(cur_addr[31:16]), 64'h0001);

    tag = "R13";
    wr(9, 'hff);
    rd(9);
    io_addr = 4'd0; io_wdata = 8'h5a; io_wr = 1'b1; io_rd = 1'b1;
    tick();
    io_wr = 1'b0; io_rd = 1'b0;
    chk("write wins over read", 64'(cur_addr[7:0]), 64'h5a);
    tick();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule